// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This block keeps wall-clock time as a single 32-bit count of elapsed seconds and pairs it with an alarm that compares the count against a stored match value. A one-cycle tick input, asserted once per second by the clock tree, advances the count whenever counting is switched on. Both halves sit behind one 8-bit register bus. A window-select bit picks either the clock window or the alarm window, and an 8-bit offset addresses a register inside that window. Each window carries an identification register, so system software can tell which half it is talking to.

The count is never snapshotted. Software loads it one byte at a time, and each byte lands in the live counter at once. Reads return the live bytes. For a safe load, the low byte is zeroed first, then the upper bytes are written, then the low byte is written last. On a read, a low byte that has gone down since the previous read shows that a carry happened. The alarm raises a level interrupt, which the interrupt controller treats as a rising edge. The interrupt stays high until software writes a one to the clear bit.

Top module: `sec_rtc`

## Requirements
- R1: After reset the count is 0, counting is enabled (clock control reads 0x80), the match value and alarm control read 0, and the interrupt is low.
- R2: Offset 0x05 reads 0x01 in the clock window and 0x03 in the alarm window. Writes to it are ignored, and unmapped offsets read 0x00.
- R3: While clock control bit 7 is set and no count byte is written, each cycle with the tick input high adds one to the count.
- R4: While clock control bit 7 is clear, the count holds its value through ticks.
- R5: The count wraps from 0xFFFFFFFF to 0 on a tick.
- R6: A write to clock-window offset 0x40+k (k = 0..3) replaces byte k of the live count in the next cycle. Other bytes are unchanged, and the count does not increment in that cycle.
- R7: Clock-window offsets 0x48+k return live byte k of the count, with byte 0 the least significant. A carry out of byte 0 shows as byte 0 dropping while byte 1 rises. Offsets 0x40..0x43 read as 0.
- R8: Clock control at offset 0x46 stores only bit 7 (count enable). Its other bits read 0.
- R9: Alarm-window offsets 0x40+k hold byte k of the 32-bit match value and can be read and written.
- R10: Alarm control 1 at offset 0x46 stores bit 7 (alarm enable) and bit 0 (abort flag). Other bits read 0. The abort flag has no effect on firing.
- R11: In a cycle where the count equals the match value and alarm enable is set, the pending flag sets on the next edge. The interrupt output equals the pending flag.
- R12: Writing alarm-window offset 0x48 with bit 0 = 1 clears the pending flag, unless the fire condition holds in that same cycle. Writing it with bit 0 = 0 has no effect.
- R13: With alarm enable clear, the pending flag never sets, even when the count passes the match value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_win | input | 1 | Window select: 0 clock, 1 alarm |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Register offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_win/bus_addr |
| alarm_irq | output | 1 | Alarm interrupt, high while pending |

## Verification
The hardest state to reach is a clear request that arrives while the fire condition still holds. The count stays equal to the match value for a full second, so a clear written during that time must lose to the re-set. The stimulus stops ticking at the match count and issues the clear while enable is still set. It then disables the alarm and clears again, which checks both outcomes at the port. The wrap and carry cases come from loading bytes directly next to the boundary, which avoids billions of ticks.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

   typedef enum logic {
      WIN_CLOCK = 1'b0,
      WIN_ALARM = 1'b1
   } rtc_win_e;

   localparam logic [7:0] OFS_SUBTYPE  = 8'h05;
   localparam logic [7:0] OFS_LANES    = 8'h40;
   localparam logic [7:0] OFS_CTL      = 8'h46;
   localparam logic [7:0] OFS_UPPER    = 8'h48;

   localparam logic [7:0] ID_CLOCK     = 8'h01;
   localparam logic [7:0] ID_ALARM     = 8'h03;

   localparam int CLK_EN_BIT   = 7;
   localparam int ALM_EN_BIT   = 7;
   localparam int ALM_ABT_BIT  = 0;
   localparam int ALM_CLR_BIT  = 0;

endpackage

// File: rtl/sec_rtc_regif.sv
module sec_rtc_regif
   import sec_rtc_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 8,
   localparam int NB    = CNT_W / BYTE_W
) (
   input  logic              win,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  count,
   input  logic              clk_en,
   input  logic [CNT_W-1:0]  match,
   input  logic              alm_en,
   input  logic              alm_abort,
   output logic [NB-1:0]     clk_lane_wr,
   output logic              clk_ctl_wr,
   output logic [NB-1:0]     alm_lane_wr,
   output logic              alm_ctl1_wr,
   output logic              alm_ctl2_wr,
   output logic [BYTE_W-1:0] rdata
);

   rtc_win_e     sel;
   logic         is_alm;
   logic [NB-1:0] lane_hit;
   logic [NB-1:0] upper_hit;

   assign sel    = rtc_win_e'(win);
   assign is_alm = (sel == WIN_ALARM);

   for (genvar k = 0; k < NB; k++) begin : g_lane_dec
      assign lane_hit[k]    = (addr == ADDR_W'(OFS_LANES + k));
      assign upper_hit[k]   = (addr == ADDR_W'(OFS_UPPER + k));
      assign clk_lane_wr[k] = wr && !is_alm && lane_hit[k];
      assign alm_lane_wr[k] = wr &&  is_alm && lane_hit[k];
   end

   assign clk_ctl_wr  = wr && !is_alm && (addr == ADDR_W'(OFS_CTL));
   assign alm_ctl1_wr = wr &&  is_alm && (addr == ADDR_W'(OFS_CTL));
   assign alm_ctl2_wr = wr &&  is_alm && (addr == ADDR_W'(OFS_UPPER));

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFS_SUBTYPE)) begin
         rdata = is_alm ? BYTE_W'(ID_ALARM) : BYTE_W'(ID_CLOCK);
      end else if (addr == ADDR_W'(OFS_CTL)) begin
         if (is_alm) begin
            rdata[ALM_EN_BIT]  = alm_en;
            rdata[ALM_ABT_BIT] = alm_abort;
         end else begin
            rdata[CLK_EN_BIT]  = clk_en;
         end
      end else begin
         for (int k = 0; k < NB; k++) begin
            if (is_alm && lane_hit[k])
               rdata = match[k*BYTE_W +: BYTE_W];
            if (!is_alm && upper_hit[k])
               rdata = count[k*BYTE_W +: BYTE_W];
         end
      end
   end

   // only one write target may be selected by a single access
   always_comb begin
      if (wr) begin
         a_one_target_r6: assert ($countones({clk_lane_wr, clk_ctl_wr, alm_lane_wr,
                                              alm_ctl1_wr, alm_ctl2_wr}) <= 1)
            else $error("regif selected two write targets");
      end
   end

endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter
   import sec_rtc_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int BYTE_W = 8,
   localparam int NB    = CNT_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [NB-1:0]     lane_wr,
   input  logic              ctl_wr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [CNT_W-1:0]  count,
   output logic              run
);

   logic [CNT_W-1:0] count_nxt;
   logic             any_lane;

   assign any_lane = |lane_wr;

   always_comb begin
      count_nxt = count;
      if (any_lane) begin
         for (int k = 0; k < NB; k++)
            if (lane_wr[k]) count_nxt[k*BYTE_W +: BYTE_W] = wdata;
      end else if (run && tick) begin
         count_nxt = count + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         run   <= 1'b1;
      end else begin
         count <= count_nxt;
         if (ctl_wr) run <= wdata[CLK_EN_BIT];
      end
   end

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !any_lane) |=> (count == $past(count) + CNT_W'(1)));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !any_lane) |=> $stable(count));

   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !any_lane && (&count)) |=> (count == '0));

   for (genvar k = 0; k < NB; k++) begin : g_lane_chk
      p_lane_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
         lane_wr[k] |=> (count[k*BYTE_W +: BYTE_W] == $past(wdata)));
      p_lane_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (any_lane && !lane_wr[k]) |=>
            (count[k*BYTE_W +: BYTE_W] == $past(count[k*BYTE_W +: BYTE_W])));
   end

endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm
   import sec_rtc_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int BYTE_W = 8,
   localparam int NB    = CNT_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  count,
   input  logic [NB-1:0]     lane_wr,
   input  logic              ctl1_wr,
   input  logic              ctl2_wr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [CNT_W-1:0]  match,
   output logic              enable,
   output logic              abort_flag,
   output logic              pending
);

   logic hit;
   logic fire;
   logic clr_req;

   assign hit     = (count == match);
   assign fire    = hit && enable;
   assign clr_req = ctl2_wr && wdata[ALM_CLR_BIT];

   for (genvar k = 0; k < NB; k++) begin : g_match
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          match[k*BYTE_W +: BYTE_W] <= '0;
         else if (lane_wr[k]) match[k*BYTE_W +: BYTE_W] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable     <= 1'b0;
         abort_flag <= 1'b0;
      end else if (ctl1_wr) begin
         enable     <= wdata[ALM_EN_BIT];
         abort_flag <= wdata[ALM_ABT_BIT];
      end
   end

   // setting wins over a simultaneous clear so that a match is never lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pending <= 1'b0;
      else if (fire)    pending <= 1'b1;
      else if (clr_req) pending <= 1'b0;
   end

   p_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && (count == match)) |=> pending);

   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !ctl2_wr) |=> pending);

   p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pending) |-> $past(ctl2_wr && wdata[ALM_CLR_BIT]));

   p_no_fire_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> $past(enable));

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
   import sec_rtc_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              bus_win,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              alarm_irq
);

   localparam int NB = CNT_W / BYTE_W;

   if (CNT_W % BYTE_W != 0) begin : g_bad_width
      $error("CNT_W must be a whole number of bytes");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("control bit positions assume 8-bit registers");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too narrow for the register offsets");
   end

   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] match;
   logic             clk_en;
   logic             alm_en;
   logic             alm_abort;
   logic             pending;
   logic [NB-1:0]    clk_lane_wr;
   logic [NB-1:0]    alm_lane_wr;
   logic             clk_ctl_wr;
   logic             alm_ctl1_wr;
   logic             alm_ctl2_wr;

   sec_rtc_regif #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regif (
      .win         (bus_win),
      .wr          (bus_wr),
      .addr        (bus_addr),
      .count       (count),
      .clk_en      (clk_en),
      .match       (match),
      .alm_en      (alm_en),
      .alm_abort   (alm_abort),
      .clk_lane_wr (clk_lane_wr),
      .clk_ctl_wr  (clk_ctl_wr),
      .alm_lane_wr (alm_lane_wr),
      .alm_ctl1_wr (alm_ctl1_wr),
      .alm_ctl2_wr (alm_ctl2_wr),
      .rdata       (bus_rdata)
   );

   sec_rtc_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_1hz),
      .lane_wr (clk_lane_wr),
      .ctl_wr  (clk_ctl_wr),
      .wdata   (bus_wdata),
      .count   (count),
      .run     (clk_en)
   );

   sec_rtc_alarm #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_alarm (
      .clk        (clk),
      .rst_n      (rst_n),
      .count      (count),
      .lane_wr    (alm_lane_wr),
      .ctl1_wr    (alm_ctl1_wr),
      .ctl2_wr    (alm_ctl2_wr),
      .wdata      (bus_wdata),
      .match      (match),
      .enable     (alm_en),
      .abort_flag (alm_abort),
      .pending    (pending)
   );

   assign alarm_irq = pending;

   p_subtype_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_SUBTYPE)) |->
         (bus_rdata == (bus_win ? BYTE_W'(ID_ALARM) : BYTE_W'(ID_CLOCK))));

   p_ctl_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_win && bus_addr == ADDR_W'(OFS_CTL)) |->
         (bus_rdata[CLK_EN_BIT-1:0] == '0));

   p_irq_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_irq) |-> $past(alm_en && (count == match)));

endmodule

// File: tb/sec_rtc_bench.sv
module sec_rtc_bench;

   typedef struct {
      bit         is_irq;
      logic [7:0] exp;
      string      tag;
   } sb_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       bus_win = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       alarm_irq;

   int checks = 0;
   int errors = 0;
   sb_item_t sbq[$];
   event     ev_sample;
   bit       finished = 1'b0;

   always #5 clk = ~clk;

   sec_rtc u_sec_rtc (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_1hz  (tick_1hz),
      .bus_win   (bus_win),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .alarm_irq (alarm_irq)
   );

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(ev_sample);
         if (sbq.size() != 0) begin
            sb_item_t it;
            logic [7:0] act;
            it  = sbq.pop_front();
            act = it.is_irq ? {7'b0, alarm_irq} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual=0x%02h expected=0x%02h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input bit win, input logic [7:0] addr, input logic [7:0] data);
      bus_win = win; bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic exp_rd(input bit win, input logic [7:0] addr, input logic [7:0] e,
                         input string tag);
      sb_item_t it;
      bus_win = win; bus_addr = addr;
      it.is_irq = 1'b0; it.exp = e; it.tag = tag;
      sbq.push_back(it);
      #1 -> ev_sample;
      #1;
   endtask

   task automatic exp_irq(input bit e, input string tag);
      sb_item_t it;
      it.is_irq = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
      sbq.push_back(it);
      #1 -> ev_sample;
      #1;
   endtask

   task automatic exp_count(input logic [31:0] v, input string tag);
      for (int k = 0; k < 4; k++)
         exp_rd(1'b0, 8'h48 + 8'(k), v[k*8 +: 8], tag);
   endtask

   task automatic ticks(input int n);
      tick_1hz = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tick_1hz = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      exp_rd(1'b0, 8'h46, 8'h80, "R1 clock ctl after reset");
      exp_count(32'h0, "R1 count after reset");
      exp_rd(1'b1, 8'h46, 8'h00, "R1 alarm ctl after reset");
      exp_rd(1'b1, 8'h40, 8'h00, "R1 match byte0 after reset");
      exp_irq(1'b0, "R1 irq after reset");

      // identification and unmapped
      exp_rd(1'b0, 8'h05, 8'h01, "R2 clock subtype");
      exp_rd(1'b1, 8'h05, 8'h03, "R2 alarm subtype");
      wr(1'b0, 8'h05, 8'hFF);
      exp_rd(1'b0, 8'h05, 8'h01, "R2 subtype write ignored");
      exp_rd(1'b0, 8'h10, 8'h00, "R2 unmapped reads zero");

      // safe load ordering: low byte cleared, upper bytes, low byte last
      wr(1'b0, 8'h40, 8'h00);
      wr(1'b0, 8'h41, 8'h22);
      wr(1'b0, 8'h42, 8'h33);
      wr(1'b0, 8'h43, 8'h44);
      wr(1'b0, 8'h40, 8'h11);
      exp_count(32'h44332211, "R6 byte load");
      exp_rd(1'b0, 8'h40, 8'h00, "R7 write lane reads zero");

      ticks(3);
      exp_count(32'h44332214, "R3 three ticks");

      // disable counting
      wr(1'b0, 8'h46, 8'h00);
      exp_rd(1'b0, 8'h46, 8'h00, "R8 enable cleared");
      ticks(5);
      exp_count(32'h44332214, "R4 hold while disabled");
      wr(1'b0, 8'h46, 8'hFF);
      exp_rd(1'b0, 8'h46, 8'h80, "R8 only bit7 stored");

      // carry out of byte 0
      wr(1'b0, 8'h40, 8'hFF);
      exp_rd(1'b0, 8'h48, 8'hFF, "R7 byte0 before carry");
      ticks(1);
      exp_rd(1'b0, 8'h48, 8'h00, "R7 byte0 dropped on carry");
      exp_rd(1'b0, 8'h49, 8'h23, "R7 byte1 took carry");

      // wrap
      wr(1'b0, 8'h41, 8'hFF);
      wr(1'b0, 8'h42, 8'hFF);
      wr(1'b0, 8'h43, 8'hFF);
      wr(1'b0, 8'h40, 8'hFF);
      exp_count(32'hFFFFFFFF, "R6 all ones load");
      ticks(1);
      exp_count(32'h0, "R5 wrap to zero");

      // alarm match value and control
      wr(1'b1, 8'h40, 8'h05);
      wr(1'b1, 8'h41, 8'hA1);
      wr(1'b1, 8'h42, 8'hB2);
      wr(1'b1, 8'h43, 8'hC3);
      exp_rd(1'b1, 8'h41, 8'hA1, "R9 match byte1");
      exp_rd(1'b1, 8'h43, 8'hC3, "R9 match byte3");
      wr(1'b1, 8'h41, 8'h00);
      wr(1'b1, 8'h42, 8'h00);
      wr(1'b1, 8'h43, 8'h00);
      exp_rd(1'b1, 8'h40, 8'h05, "R9 match byte0");
      wr(1'b1, 8'h46, 8'hFF);
      exp_rd(1'b1, 8'h46, 8'h81, "R10 ctl1 stores bits 7 and 0");

      ticks(4);
      exp_irq(1'b0, "R11 no fire before match");
      ticks(1);
      exp_rd(1'b0, 8'h48, 8'h05, "R11 count reached match");
      exp_irq(1'b0, "R11 irq one cycle after match");
      idle(1);
      exp_irq(1'b1, "R11 irq raised");
      idle(3);
      exp_irq(1'b1, "R11 irq stays pending");

      // clear while still matching and enabled: set wins
      wr(1'b1, 8'h48, 8'h01);
      exp_irq(1'b1, "R12 clear loses to live match");
      wr(1'b1, 8'h46, 8'h01);
      wr(1'b1, 8'h48, 8'h00);
      exp_irq(1'b1, "R12 zero bit does not clear");
      wr(1'b1, 8'h48, 8'h01);
      exp_irq(1'b0, "R12 clear drops irq");
      exp_rd(1'b1, 8'h46, 8'h01, "R10 abort kept after disable");

      // disabled alarm never fires
      idle(3);
      exp_irq(1'b0, "R13 match held with alarm off");
      wr(1'b1, 8'h40, 8'h08);
      ticks(5);
      exp_rd(1'b0, 8'h48, 8'h0A, "R13 count passed match");
      exp_irq(1'b0, "R13 no fire while disabled");

      // abort flag clear: fires exactly the same
      wr(1'b1, 8'h40, 8'h0C);
      wr(1'b1, 8'h46, 8'h80);
      exp_rd(1'b1, 8'h46, 8'h80, "R10 abort cleared");
      ticks(2);
      idle(1);
      exp_irq(1'b1, "R10 fires with abort clear");

      if (sbq.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual=%0d expected=0 items left", sbq.size());
      end
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule